// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block derives a reference clock from its base clock. The output period is the base period multiplied by a power of two, from 1 to 128, and the high time can be a quarter, a half or three quarters of that period, or zero. All settings live in one 8-bit control register. The register has an enable bit, a duty field and a divider field. It is written through a single-cycle synchronous write strobe and can be read back at any time.

When the divider code is zero, the base clock is gated straight through to the output and the duty field has no effect. A change to the divider or duty field waits in the control register until the current output period ends. This keeps partial pulses off the output. Enabling the block always starts a fresh period whose first cycle drives the output high. Clearing the enable bit holds the output low.

Top module: `refClkGen`

## Requirements
- R1: After reset the register reads 0x10 (enable 0, duty code 10, divider code 000) and the output is low.
- R2: The register layout is enable in bit 7, duty code in bits 4:3 and divider code in bits 2:0. A write stores these fields, and bits 6:5 always read back as 0.
- R3: With divider code n from 1 to 7 and enable set, the output repeats every 2^n base cycles.
- R4: With divider code n ≥ 1, the output is high for the first floor(d·2^n/4) base cycles of each period, where d is the duty code value (00=0, 01=1, 10=2, 11=3). Duty code 00 keeps the output low.
- R5: With divider code 000 and enable set, the output follows the base clock level whatever the duty code.
- R6: While the enable bit is 0, the output is held low.
- R7: A write that sets enable while the block is disabled starts a new period. The output is high in the first base cycle after that write edge if the high count is nonzero.
- R8: A divider or duty change written mid-period does not alter the current period. It applies from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write value |
| rdData | output | 8 | Current register contents |
| clkOut | output | 1 | Reference clock output |

## Verification
The bench builds the block with its package defaults: a 3-bit divider code, a 2-bit duty code and a 7-bit period counter. These defaults put the whole ratio range from pass-through to divide-by-128 within reach, together with the rounding corners at divide-by-2 and divide-by-4. A behavioural model predicts the output level in both clock phases, and the register value, on every cycle. The bench then sweeps all 32 divider and duty combinations and counts high cycles and rising edges over whole periods. It also writes new settings mid-period and toggles the enable bit to reach the boundary and restart cases.

// File: rtl/refClkPkg.sv
package refClkPkg;
  localparam int REG_W    = 8;
  localparam int DIV_W    = 3;
  localparam int DUTY_W   = 2;
  localparam int CNT_W    = (1 << DIV_W) - 1;
  localparam int EN_BIT   = REG_W - 1;
  localparam int DUTY_LSB = DIV_W;
  localparam int DIV_LSB  = 0;

  localparam logic [REG_W-1:0] RESET_VAL = 8'h10;
  localparam logic [REG_W-1:0] WR_MASK   = 8'h9F;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  typedef struct packed {
    logic restart;
    logic live;
  } strb_t;
endpackage

// File: rtl/refClkCtrl.sv
module refClkCtrl
  import refClkPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             atEnd,
  output logic [REG_W-1:0] regQ,
  output cfg_t             cfgNext,
  output strb_t            strb
);
  logic [REG_W-1:0] regNext;
  logic             enQ;
  logic             enNext;

  assign regNext = wrEn ? (wrData & WR_MASK) : regQ;
  assign enQ     = regQ[EN_BIT];
  assign enNext  = regNext[EN_BIT];

  assign cfgNext.duty = regNext[DUTY_LSB +: DUTY_W];
  assign cfgNext.div  = regNext[DIV_LSB +: DIV_W];

  // restart: hold the counter at zero while disabled, start fresh on
  // enable, and reload the settings at every period boundary
  assign strb.restart = !enNext || !enQ || atEnd;
  assign strb.live    = enQ;

  always_ff @(posedge clk) begin
    if (rst) regQ <= RESET_VAL;
    else     regQ <= regNext;
  end
endmodule

// File: rtl/refClkPath.sv
module refClkPath
  import refClkPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strb_t            strb,
  input  cfg_t             cfgNext,
  output logic             atEnd,
  output logic             clkOut,
  output cfg_t             actCfg,
  output logic [CNT_W-1:0] cntQ
);
  localparam cfg_t RESET_CFG = '{duty: RESET_VAL[DUTY_LSB +: DUTY_W],
                                 div:  RESET_VAL[DIV_LSB +: DIV_W]};

  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   highCnt;
  logic             phaseHigh;
  logic             passThru;

  assign lastIdx = ~({CNT_W{1'b1}} << actCfg.div);
  assign span    = {1'b0, lastIdx} + {{CNT_W{1'b0}}, 1'b1};
  assign atEnd   = (cntQ == lastIdx);

  // floor(duty*span/4) built from shifts of a power of two
  always_comb begin
    case (actCfg.duty)
      2'd1:    highCnt = span >> 2;
      2'd2:    highCnt = span >> 1;
      2'd3:    highCnt = (span >> 1) + (span >> 2);
      default: highCnt = '0;
    endcase
  end

  assign phaseHigh = ({1'b0, cntQ} < highCnt);
  assign passThru  = (actCfg.div == '0);
  assign clkOut    = strb.live && (passThru ? clk : phaseHigh);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ   <= '0;
      actCfg <= RESET_CFG;
    end else if (strb.restart) begin
      cntQ   <= '0;
      actCfg <= cfgNext;
    end else begin
      cntQ   <= cntQ + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/refClkGen.sv
module refClkGen
  import refClkPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             clkOut
);
  strb_t            strb;
  cfg_t             cfgNext;
  cfg_t             actCfg;
  logic             atEnd;
  logic [CNT_W-1:0] cntQ;

  refClkCtrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .atEnd   (atEnd),
    .regQ    (rdData),
    .cfgNext (cfgNext),
    .strb    (strb)
  );

  refClkPath u_path (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .cfgNext (cfgNext),
    .atEnd   (atEnd),
    .clkOut  (clkOut),
    .actCfg  (actCfg),
    .cntQ    (cntQ)
  );
endmodule

// File: rtl/refClkGenChk.sv
module refClkGenChk
  import refClkPkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             clkOut,
  input logic             atEnd,
  input cfg_t             actCfg,
  input logic [CNT_W-1:0] cntQ
);
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdData[6:5] == 2'b00); // R2

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> rdData == ($past(wrData) & WR_MASK)); // R2

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !rdData[EN_BIT] |-> !clkOut); // R6

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cntQ} < ({{CNT_W{1'b0}}, 1'b1} << actCfg.div)); // R3

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (rdData[EN_BIT] && actCfg.div != '0 && actCfg.duty == '0) |-> !clkOut); // R4

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdData[EN_BIT] && !atEnd && !(wrEn && !wrData[EN_BIT])) |=> $stable(actCfg)); // R8
endmodule

bind refClkGen refClkGenChk u_refClkGenChk (
  .clk    (clk),
  .rst    (rst),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .clkOut (clkOut),
  .atEnd  (atEnd),
  .actCfg (actCfg),
  .cntQ   (cntQ)
);

// File: tb/test_refClkGen.sv
module test_refClkGen;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       clkOut;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] mReg = 8'h10;
  int mPos = 0;
  int mDiv = 0;
  int mDuty = 2;

  refClkGen i_refClkGen (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .clkOut(clkOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int hiCount(int d, int dt);
    return (dt * (1 << d)) / 4;
  endfunction

  always @(posedge clk) begin
    logic [7:0] nReg;
    if (rst) begin
      mReg = 8'h10; mPos = 0; mDiv = 0; mDuty = 2;
    end else begin
      nReg = wrEn ? (wrData & 8'h9F) : mReg;
      if (!nReg[7] || !mReg[7] || mPos == (1 << mDiv) - 1) begin
        mPos = 0; mDiv = int'(nReg[2:0]); mDuty = int'(nReg[4:3]);
      end else begin
        mPos++;
      end
      mReg = nReg;
    end
  end

  function automatic logic expOut(logic level);
    if (!mReg[7]) return 1'b0;
    if (mDiv == 0) return level;
    return logic'(mPos < hiCount(mDiv, mDuty));
  endfunction

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic modelCompare(logic level);
    string tag;
    if (!mReg[7]) tag = "R6";
    else if (mDiv == 0) tag = "R5";
    else if (mDuty == 0) tag = "R4";
    else tag = "R3";
    check(tag, int'(clkOut), int'(expOut(level)));
    check("R2", int'(rdData), int'(mReg));
  endtask

  initial begin
    forever begin
      @(posedge clk); #(Q);
      if (!done) modelCompare(1'b1);
      @(negedge clk); #(Q);
      if (!done) modelCompare(1'b0);
    end
  end

  task automatic wrReg(logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int cnt;
    int rises;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #(Q);
    check("R1", int'(rdData), 8'h10);
    check("R1", int'(clkOut), 0);

    // R2: unimplemented bits read as zero
    wrReg(8'hFF);
    #(Q); check("R2", int'(rdData), 8'h9F);
    wrReg(8'h60);
    #(Q); check("R2", int'(rdData), 8'h00);

    // R3 R4 R5: sweep of every divider and duty setting
    for (int d = 0; d < 8; d++) begin
      for (int dt = 0; dt < 4; dt++) begin
        wrReg(8'h80 | 8'(dt << 3) | 8'(d));
        repeat (260) @(negedge clk);
        if (d == 0) begin
          cnt = 0;
          for (int k = 0; k < 4; k++) begin
            @(posedge clk); #(Q);
            if (clkOut) cnt++;
          end
          check("R5", cnt, 4);
        end else begin
          cnt = 0;
          for (int k = 0; k < 2 * (1 << d); k++) begin
            @(negedge clk); #(Q);
            if (clkOut) cnt++;
          end
          check("R4", cnt, 2 * hiCount(d, dt));
          rises = 0;
          prev = clkOut;
          for (int k = 0; k < 4 * (1 << d); k++) begin
            @(negedge clk); #(Q);
            if (clkOut && !prev) rises++;
            prev = clkOut;
          end
          check("R3", rises, (hiCount(d, dt) > 0) ? 4 : 0);
        end
      end
    end

    // R6: disabled output stays low
    wrReg(8'h1A);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #(Q); if (clkOut) cnt++;
      @(negedge clk); #(Q); if (clkOut) cnt++;
    end
    check("R6", cnt, 0);

    // R7: enabling starts a fresh period high
    wrReg(8'h8B);
    #(Q); check("R7", int'(clkOut), 1);
    repeat (20) @(negedge clk);

    // R8: mid-period change waits for the boundary
    wrReg(8'h00);
    wrReg(8'h95);
    #(Q); check("R8", int'(clkOut), 1);
    wrReg(8'h91);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      #(Q); if (clkOut) cnt++;
      @(negedge clk);
    end
    check("R8", cnt, 8);
    repeat (30) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #(Q); if (clkOut) cnt++;
    end
    check("R8", cnt, 4);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule